// File: doc/BRIEF.md
# Line Drawing Engine

This block draws straight lines into a 1920 by 1080 frame buffer held in a synchronous SRAM. A host processor sets up a line through a small register port. It writes the start point, the end column and a 16-bit RGB565 color. Writing the end row is what starts the draw. The engine then walks the line with an integer error-term stepper and emits one pixel write per clock until it reaches the end point.

While a line is being drawn, the ready output to the host is held low, so the processor stalls until the line is complete. Every register can be read back. Software can therefore adjust a value in place, for example increment an endpoint. Rewriting only the end row redraws from the endpoints already held. Each pixel goes to SRAM address `row * 1920 + column`. The write strobe is asserted in the same cycle as its address and data.

Top module: `line_raster_engine`

## Requirements
- R1: After reset, `cpu_rdy` is 1 and `sram_we` is 0, and every register reads back as 0.
- R2: Register selects are 0 = start column, 1 = start row, 2 = end column, 3 = end row, 4 = color. Writes to selects 0, 1, 2 and 4 store the value, which reads back through `reg_rdata`. Such writes start no draw: `cpu_rdy` stays 1 and `sram_we` stays 0.
- R3: A write to select 3 while idle starts a draw. From the next cycle on, `cpu_rdy` is 0 and `sram_we` is 1, and the first pixel written is the start point.
- R4: Each pixel write has `sram_addr = row*1920 + column` and `sram_wdata` equal to the color held when the draw began. A color write made during the draw changes the stored register but not the pixels of that line. The strobe, the address and the data share one cycle.
- R5: Pixels are written on consecutive cycles, one per clock, with no gap. The last pixel is the end point. In the cycle after it, `sram_we` is 0 and `cpu_rdy` is 1. A line writes max(|dx|,|dy|)+1 pixels.
- R6: The stepper starts with e = |dx| - |dy|. After each pixel that is not the end point, it doubles e. If 2e >= -|dy|, it adds -|dy| to e and steps the column one toward the end. If 2e <= |dx|, it adds |dx| to e and steps the row one toward the end. This covers all eight directions.
- R7: Horizontal, vertical and single-point lines are drawn, with a single point writing exactly one pixel.
- R8: Full-screen diagonals between opposite corners, (0,0) to (1919,1079) and the reverse, and (0,1079) to (1919,0), are drawn exactly.
- R9: A write to select 3 during a draw is ignored. The line in progress is unchanged and the end row reads back its old value afterwards.
- R10: A value read back, changed and written again is stored. Rewriting only select 3 draws a new line from the held start point and end column.
- R11: Selects 5 to 7 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| cpu_rdy | output | 1 | High when the host may proceed; low while drawing |
| sram_we | output | 1 | SRAM pixel write strobe |
| sram_addr | output | 21 | SRAM pixel address |
| sram_wdata | output | 16 | SRAM pixel data (RGB565) |

## Verification
A wrong error term or step direction shows at the ports as a wrong address on the very pixel where the stepper diverges. The check compares every emitted address against a model that runs alongside the engine. A bad termination shows as a pixel count that is off, or a ready line that returns early or late, within one cycle of the expected end. A stale color or row base appears on the first write of a line, and a y1 write during a draw that leaks through alters the pixel stream within a cycle.

// File: rtl/line_raster_engine.sv
module line_raster_engine #(
  parameter int H_RES  = 1920,
  parameter int V_RES  = 1080,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cpu_rdy,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata
);
  localparam int CW = $clog2(H_RES > V_RES ? H_RES : V_RES);
  localparam int EW = CW + 3;
  localparam logic [2:0] SEL_X0 = 3'd0;
  localparam logic [2:0] SEL_Y0 = 3'd1;
  localparam logic [2:0] SEL_X1 = 3'd2;
  localparam logic [2:0] SEL_Y1 = 3'd3;
  localparam logic [2:0] SEL_COL = 3'd4;

  logic [CW-1:0] x0_q, y0_q, x1_q, y1_q, y1_new;
  logic [DATA_W-1:0] col_q, pix_q;
  logic busy, start, at_end, step_x, step_y, stx, sty;
  logic [CW-1:0] cx, cy, ex, ey;
  logic [ADDR_W-1:0] row_q;
  logic signed [EW-1:0] ddx, ddy, adx, ady, err, e2, sdx, sdy;

  assign y1_new = reg_wdata[CW-1:0];
  assign start  = reg_wr && (reg_sel == SEL_Y1) && !busy;
  assign ddx    = $signed({{(EW-CW){1'b0}}, x1_q}) - $signed({{(EW-CW){1'b0}}, x0_q});
  assign ddy    = $signed({{(EW-CW){1'b0}}, y1_new}) - $signed({{(EW-CW){1'b0}}, y0_q});
  assign adx    = ddx[EW-1] ? -ddx : ddx;
  assign ady    = ddy[EW-1] ? -ddy : ddy;
  assign e2     = err <<< 1;
  assign step_x = (e2 >= sdy);
  assign step_y = (e2 <= sdx);
  assign at_end = (cx == ex) && (cy == ey);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x0_q  <= '0;
      y0_q  <= '0;
      x1_q  <= '0;
      y1_q  <= '0;
      col_q <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_X0:  x0_q <= reg_wdata[CW-1:0];
        SEL_Y0:  y0_q <= reg_wdata[CW-1:0];
        SEL_X1:  x1_q <= reg_wdata[CW-1:0];
        SEL_Y1:  if (!busy) y1_q <= y1_new;
        SEL_COL: col_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cx    <= '0;
      cy    <= '0;
      ex    <= '0;
      ey    <= '0;
      row_q <= '0;
      err   <= '0;
      sdx   <= '0;
      sdy   <= '0;
      stx   <= 1'b0;
      sty   <= 1'b0;
      pix_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cx    <= x0_q;
      cy    <= y0_q;
      ex    <= x1_q;
      ey    <= y1_new;
      row_q <= ADDR_W'(y0_q) * ADDR_W'(H_RES);
      sdx   <= adx;
      sdy   <= -ady;
      err   <= adx - ady;
      stx   <= ddx[EW-1];
      sty   <= ddy[EW-1];
      pix_q <= col_q;
    end else if (busy) begin
      if (at_end) begin
        busy <= 1'b0;
      end else begin
        if (step_x) cx <= stx ? cx - 1'b1 : cx + 1'b1;
        if (step_y) begin
          cy    <= sty ? cy - 1'b1 : cy + 1'b1;
          row_q <= sty ? row_q - ADDR_W'(H_RES) : row_q + ADDR_W'(H_RES);
        end
        err <= err + (step_x ? sdy : '0) + (step_y ? sdx : '0);
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_X0:  reg_rdata = DATA_W'(x0_q);
      SEL_Y0:  reg_rdata = DATA_W'(y0_q);
      SEL_X1:  reg_rdata = DATA_W'(x1_q);
      SEL_Y1:  reg_rdata = DATA_W'(y1_q);
      SEL_COL: reg_rdata = col_q;
      default: reg_rdata = '0;
    endcase
  end

  assign cpu_rdy    = !busy;
  assign sram_we    = busy;
  assign sram_addr  = row_q + ADDR_W'(cx);
  assign sram_wdata = pix_q;
endmodule

// File: rtl/line_raster_engine_chk.sv
module line_raster_engine_chk #(
  parameter int H_RES  = 1920,
  parameter int V_RES  = 1080,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic              cpu_rdy,
  input logic              sram_we,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_wdata
);
  logic [ADDR_W-1:0] prev_addr;
  logic signed [ADDR_W+1:0] d;

  always_ff @(posedge clk) prev_addr <= sram_addr;
  assign d = $signed({2'b00, sram_addr}) - $signed({2'b00, prev_addr});

  // R3
  start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd3 && cpu_rdy) |=> (!cpu_rdy && sram_we));

  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (int'(sram_addr) < H_RES * V_RES));

  // R4
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && $past(sram_we)) |-> $stable(sram_wdata));

  // R6
  step_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && $past(sram_we)) |->
      (d == 1 || d == -1 || d == H_RES || d == -H_RES ||
       d == H_RES + 1 || d == -(H_RES + 1) || d == H_RES - 1 || d == -(H_RES - 1)));
endmodule

bind line_raster_engine line_raster_engine_chk #(
  .H_RES(H_RES), .V_RES(V_RES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .cpu_rdy(cpu_rdy), .sram_we(sram_we), .sram_addr(sram_addr),
  .sram_wdata(sram_wdata)
);

// File: tb/line_raster_engine_tb_top.sv
module line_raster_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 1920;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0, reg_rdata, sram_wdata;
  logic cpu_rdy, sram_we;
  logic [20:0] sram_addr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_raster_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_rdy(cpu_rdy),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel;
    #1 check(reg_rdata === exp, $sformatf("%s read sel %0d: actual %h expected %h", tag, sel, reg_rdata, exp));
  endtask

  // Runs one line against the stepping rule of R6; optional write injected during the draw.
  task automatic run_line(input int x0, input int y0, input int x1, input int y1,
                          input logic [15:0] col, input bit only_y1,
                          input bit inj, input logic [2:0] inj_sel, input logic [15:0] inj_dat,
                          input string tag);
    int x = x0, y = y0, k = 0, bad = 0;
    int dx = (x1 > x0) ? x1 - x0 : x0 - x1;
    int dy = (y1 > y0) ? y0 - y1 : y1 - y0;
    int sx = (x1 >= x0) ? 1 : -1;
    int sy = (y1 >= y0) ? 1 : -1;
    int err = dx + dy;
    string first = "";
    if (!only_y1) begin
      wr_reg(3'd0, 16'(x0));
      wr_reg(3'd1, 16'(y0));
      wr_reg(3'd2, 16'(x1));
      wr_reg(3'd4, col);
    end
    wr_reg(3'd3, 16'(y1));
    forever begin
      @(negedge clk);
      if (inj && k == 2) begin reg_sel = inj_sel; reg_wdata = inj_dat; reg_wr = 1'b1; end
      if (inj && k == 3) reg_wr = 1'b0;
      if (!(sram_we === 1'b1 && cpu_rdy === 1'b0 && sram_addr === 21'(y*H + x) && sram_wdata === col)) begin
        if (bad == 0)
          first = $sformatf("pixel %0d: actual we=%b rdy=%b addr=%0d data=%h expected we=1 rdy=0 addr=%0d data=%h",
                            k, sram_we, cpu_rdy, sram_addr, sram_wdata, y*H + x, col);
        bad++;
      end
      if ((x == x1 && y == y1) || k > 5000) break;
      begin
        int e2 = 2 * err;
        if (e2 >= dy) begin err += dy; x += sx; end
        if (e2 <= dx) begin err += dx; y += sy; end
      end
      k++;
    end
    reg_wr = 1'b0;
    check(bad == 0, $sformatf("%s R3 R4 R5 (%0d,%0d)->(%0d,%0d) %s", tag, x0, y0, x1, y1, first));
    @(negedge clk);
    check(sram_we === 1'b0 && cpu_rdy === 1'b1,
          $sformatf("%s R5 end: actual we=%b rdy=%b expected we=0 rdy=1", tag, sram_we, cpu_rdy));
  endtask

  task automatic t_reset;
    check(cpu_rdy === 1'b1 && sram_we === 1'b0,
          $sformatf("R1 reset outputs: actual rdy=%b we=%b expected 1 0", cpu_rdy, sram_we));
    for (int s = 0; s < 5; s++) rd_check(3'(s), 16'h0000, "R1");
  endtask

  task automatic t_latch;
    int quiet = 1;
    wr_reg(3'd0, 16'd5);
    wr_reg(3'd1, 16'd7);
    wr_reg(3'd2, 16'd9);
    wr_reg(3'd4, 16'hABCD);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (sram_we !== 1'b0 || cpu_rdy !== 1'b1) quiet = 0;
    end
    check(quiet == 1, $sformatf("R2 no draw: actual quiet=%0d expected 1", quiet));
    rd_check(3'd0, 16'd5, "R2");
    rd_check(3'd1, 16'd7, "R2");
    rd_check(3'd2, 16'd9, "R2");
    rd_check(3'd4, 16'hABCD, "R2");
  endtask

  task automatic t_unmapped;
    rd_check(3'd5, 16'h0000, "R11");
    rd_check(3'd7, 16'h0000, "R11");
  endtask

  task automatic t_octants;
    run_line(10, 10, 20, 14, 16'hF800, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(20, 14, 10, 10, 16'h07E0, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(10, 10, 13, 25, 16'h001F, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(13, 25, 10, 10, 16'hFFFF, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(50, 10, 40, 18, 16'h1234, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(40, 18, 50, 10, 16'h4321, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(5, 40, 8, 30, 16'h0F0F, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(8, 30, 5, 40, 16'hF0F0, 0, 0, 3'd0, 16'd0, "R6 oct");
    run_line(30, 30, 37, 37, 16'h5555, 0, 0, 3'd0, 16'd0, "R6 diag45");
  endtask

  task automatic t_degenerate;
    run_line(0, 5, 30, 5, 16'hAAAA, 0, 0, 3'd0, 16'd0, "R7 horiz");
    run_line(7, 20, 7, 0, 16'hBBBB, 0, 0, 3'd0, 16'd0, "R7 vert");
    run_line(100, 100, 100, 100, 16'hCCCC, 0, 0, 3'd0, 16'd0, "R7 point");
  endtask

  task automatic t_fullscreen;
    run_line(0, 0, 1919, 1079, 16'h07FF, 0, 0, 3'd0, 16'd0, "R8 diag");
    run_line(1919, 1079, 0, 0, 16'hF81F, 0, 0, 3'd0, 16'd0, "R8 diag rev");
    run_line(0, 1079, 1919, 0, 16'hFFE0, 0, 0, 3'd0, 16'd0, "R8 anti");
  endtask

  task automatic t_busy_writes;
    run_line(0, 0, 60, 0, 16'h2222, 0, 1, 3'd3, 16'd40, "R9 y1 busy");
    rd_check(3'd3, 16'd0, "R9 y1 kept");
    run_line(0, 0, 20, 6, 16'h3333, 0, 1, 3'd4, 16'h1111, "R4 color busy");
    rd_check(3'd4, 16'h1111, "R4 color stored");
  endtask

  task automatic t_redraw;
    logic [15:0] v;
    wr_reg(3'd0, 16'd200);
    wr_reg(3'd1, 16'd300);
    wr_reg(3'd2, 16'd210);
    wr_reg(3'd4, 16'h7777);
    @(negedge clk);
    reg_sel = 3'd2;
    #1 v = reg_rdata;
    wr_reg(3'd2, v + 16'd1);
    rd_check(3'd2, 16'd211, "R10 rmw");
    run_line(200, 300, 211, 304, 16'h7777, 1, 0, 3'd0, 16'd0, "R10 first");
    run_line(200, 300, 211, 290, 16'h7777, 1, 0, 3'd0, 16'd0, "R10 redraw");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_unmapped();
    t_octants();
    t_degenerate();
    t_fullscreen();
    t_busy_writes();
    t_redraw();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule